// File: doc/BRIEF.md
# Interrupt and Stack Sequencer

This block is the multi-cycle sequencer that an 8-bit processor core uses for every operation that touches the hardware stack or redirects control through a vector. It covers power-up start, edge-triggered non-maskable interrupts, level-triggered maskable interrupts, software break, subroutine call and return, return from interrupt, and the four single-byte push and pull operations for the accumulator and the status byte. It owns the program counter, the 8-bit stack pointer and the status byte. It makes exactly one access per cycle on a byte-wide memory bus with a 16-bit address. The memory returns read data in the same cycle.

An external decoder asks for an operation with a one-cycle `start_i` strobe and a 3-bit command code. The sequencer starts its bus accesses on the next cycle. When the last access is done it raises `done_o` for one cycle. While idle, the sequencer is at an instruction boundary. At that point a pending non-maskable interrupt goes first, then a permitted maskable interrupt, then the decoder's strobe. The accumulator is not stored here: its value comes in on `acc_i`, and a pulled value goes out on `acc_o` with a write pulse.

Top module: `int_stack_seq`

## Requirements
- R1: While `rst_n` is low, and through the start-up sequence that follows, `sp_o` reads 0xFF, `status_o` reads 0x00 and `regs_clr_o` is high. The sequence reads address 0xFFFC into the low byte of `pc_o` and then 0xFFFD into the high byte.
- R2: Every stack access drives address 0x0100 + `sp_o`, and the pointer wraps within 8 bits. A push writes at the current pointer and then decrements it. A pull increments the pointer and then reads at the new value. A write only ever goes to the stack page.
- R3: Interrupt entry writes three bytes in this order: PC high, PC low, status. It then reads the vector low byte and then the vector high byte. After that, status bit 2 (interrupt disable) is set. The non-maskable vector is at 0xFFFA and the maskable vector is at 0xFFFE.
- R4: A rising edge on `nmi_i` is latched until it is serviced, even if it arrives while the sequencer is busy. It is serviced whatever status bit 2 holds. When both requests are present, it wins over `irq_i`. `irq_i` is a level input and is accepted only when the sequencer is idle and status bit 2 is clear.
- R5: Command 0 (break) adds one to the PC and sets status bits 4 and 5 before it pushes. It then vectors through 0xFFFE and sets bit 2.
- R6: Command 4 pushes `acc_i`. Command 5 pushes the status byte with bits 4 and 5 forced to one in the written byte only.
- R7: Command 7 (pull status) and the status pull inside return-from-interrupt change only the bits in mask 0xCF (bits 7,6,3,2,1,0). Bits 4 and 5 keep their value.
- R8: Command 1 (call) first does a dummy read at the stack address. It then pushes the PC high byte and then the PC low byte. Last, it reads the target high byte at the PC. The new PC is {that byte, `opnd_lo_i`}.
- R9: Command 2 (return) pulls the PC low byte and then the high byte. It then uses a fourth cycle to add one, so four bus cycles in total.
- R10: Command 3 (return from interrupt) pulls the status byte, then the PC low byte, then the PC high byte. It does not add one.
- R11: Command 6 pulls a byte into `acc_o` and pulses `acc_we_o`. It sets status bit 7 from bit 7 of that byte and sets bit 1 when the byte is zero.
- R12: `done_o` is a single-cycle pulse in the cycle after the last bus access. A strobe that arrives while busy is ignored. A strobe in an idle cycle where an interrupt is taken is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; starts the start-up sequence |
| nmi_i | input | 1 | Non-maskable request, rising-edge sensitive |
| irq_i | input | 1 | Maskable request, level sensitive |
| start_i | input | 1 | One-cycle strobe from the decoder |
| cmd_i | input | 3 | Command code: 0 break, 1 call, 2 return, 3 return from interrupt, 4 push A, 5 push status, 6 pull A, 7 pull status |
| opnd_lo_i | input | 8 | Call target low byte, sampled with the strobe |
| acc_i | input | 8 | Accumulator value for push A |
| rdata_i | input | 8 | Read data for the current address, same cycle |
| addr_o | output | 16 | Bus address |
| wdata_o | output | 8 | Write data |
| we_o | output | 1 | Write enable |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | Sequence-finished pulse |
| pc_o | output | 16 | Program counter |
| sp_o | output | 8 | Stack pointer |
| status_o | output | 8 | Status byte (N7 V6 U5 B4 D3 I2 Z1 C0) |
| acc_o | output | 8 | Pulled accumulator value |
| acc_we_o | output | 1 | Accumulator write pulse |
| regs_clr_o | output | 1 | Clear A, X and Y; high during the start-up sequence |

## Verification
The pull-status and return-from-interrupt paths are fed both 0xFF and 0x30. The first shows that bits 4 and 5 are never loaded. The second shows they are never cleared once a break has set them. Accumulator pulls use 0x80 and 0x00 so that the N and Z updates each show up alone. One pull runs with the pointer at 0xFF and one push with it at 0x00, to expose any carry into the page byte. The interrupt tests cover a masked request, a non-maskable request while the mask is set, both requests in the same cycle, and a non-maskable edge that arrives while the sequencer is busy. Together these separate priority from masking and from latching. Call and return are run as a pair, with a stray strobe during the call, to check the byte order, the +1 adjustment and that a busy sequencer takes no new command.

// File: rtl/int_stack_seq_pkg.sv
// Package: shared sequence kinds and status-byte constants.
// Assumes an 8-bit status byte laid out N7 V6 U5 B4 D3 I2 Z1 C0.
package int_stack_seq_pkg;

    typedef enum logic [3:0] {
        K_RST, K_NMI, K_IRQ, K_BRK, K_CALL, K_RET,
        K_RETI, K_PUSHA, K_PUSHP, K_PULLA, K_PULLP
    } seq_kind_e;

    localparam int ST_Z = 1;
    localparam int ST_I = 2;
    localparam int ST_N = 7;
    localparam logic [7:0] ST_PULL_MASK  = 8'hCF;
    localparam logic [7:0] ST_PUSH_FORCE = 8'h30;

    // Map the decoder's 3-bit command code onto a sequence kind.
    function automatic seq_kind_e cmd_to_kind(input logic [2:0] code);
        case (code)
            3'd0:    return K_BRK;
            3'd1:    return K_CALL;
            3'd2:    return K_RET;
            3'd3:    return K_RETI;
            3'd4:    return K_PUSHA;
            3'd5:    return K_PUSHP;
            3'd6:    return K_PULLA;
            default: return K_PULLP;
        endcase
    endfunction

    // Index of the final bus cycle of each sequence kind.
    function automatic logic [2:0] last_step(input seq_kind_e k);
        case (k)
            K_RST:                return 3'd1;
            K_NMI, K_IRQ, K_BRK:  return 3'd4;
            K_CALL, K_RET, K_RETI: return 3'd3;
            K_PULLA, K_PULLP:     return 3'd1;
            default:              return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/int_stack_seq_arb.sv
// Boundary arbiter: latches non-maskable edges and, when the sequencer is
// idle, grants one request in the order NMI, IRQ, decoder strobe.
// Assumes idle_i is high exactly at instruction boundaries.
module int_stack_seq_arb
    import int_stack_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       nmi_i,
    input  logic       irq_i,
    input  logic       irq_mask_i,
    input  logic       idle_i,
    input  logic       start_i,
    input  logic [2:0] cmd_i,
    output logic       go_o,
    output seq_kind_e  kind_o
);
    logic nmi_q, nmi_pend, nmi_edge, nmi_now, take_nmi, take_irq;

    assign nmi_edge = nmi_i && !nmi_q;
    assign nmi_now  = nmi_pend || nmi_edge;
    assign take_nmi = idle_i && nmi_now;
    assign take_irq = idle_i && !nmi_now && irq_i && !irq_mask_i;

    // Edge detector and pending latch for the non-maskable request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q    <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            nmi_q <= nmi_i;
            if (take_nmi)      nmi_pend <= 1'b0;
            else if (nmi_edge) nmi_pend <= 1'b1;
        end
    end

    // Grant selection by fixed priority.
    always_comb begin
        go_o   = 1'b0;
        kind_o = cmd_to_kind(cmd_i);
        if (take_nmi) begin
            go_o   = 1'b1;
            kind_o = K_NMI;
        end else if (take_irq) begin
            go_o   = 1'b1;
            kind_o = K_IRQ;
        end else if (idle_i && start_i) begin
            go_o = 1'b1;
        end
    end
endmodule

// File: rtl/int_stack_seq_sp.sv
// Stack pointer: 8-bit pointer in a fixed page, post-decrement on push,
// pre-increment on pull. Assumes push and pull are never both requested.
module int_stack_seq_sp #(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter logic [AW-DW-1:0] STACK_PAGE = 'h01
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pull_i,
    output logic [DW-1:0] sp_o,
    output logic [AW-1:0] addr_o
);
    logic [DW-1:0] sp_q;

    // Pointer update; reset to the top of the page.
    always_ff @(posedge clk) begin
        if (!rst_n)      sp_q <= '1;
        else if (push_i) sp_q <= sp_q - 1'b1;
        else if (pull_i) sp_q <= sp_q + 1'b1;
    end

    assign sp_o   = sp_q;
    assign addr_o = {STACK_PAGE, sp_q};
endmodule

// File: rtl/int_stack_seq_status.sv
// Status byte: masked load from a pull, N/Z update from a pulled value,
// break marks and interrupt-disable set. Assumes one request per cycle.
module int_stack_seq_status
    import int_stack_seq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_idis_i,
    input  logic          set_brk_i,
    input  logic          load_i,
    input  logic          nz_i,
    input  logic [DW-1:0] val_i,
    output logic [DW-1:0] stat_o
);
    localparam logic [DW-1:0] MASK  = DW'(ST_PULL_MASK);
    localparam logic [DW-1:0] FORCE = DW'(ST_PUSH_FORCE);

    logic [DW-1:0] st_q;

    // Status register update by request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (load_i) begin
            st_q <= (st_q & ~MASK) | (val_i & MASK);
        end else if (nz_i) begin
            st_q[ST_N] <= val_i[DW-1];
            st_q[ST_Z] <= (val_i == '0);
        end else if (set_brk_i) begin
            st_q <= st_q | FORCE;
        end else if (set_idis_i) begin
            st_q[ST_I] <= 1'b1;
        end
    end

    assign stat_o = st_q;
endmodule

// File: rtl/int_stack_seq.sv
// Interrupt and stack sequencer top. Owns PC, stack pointer and status, and
// makes one bus access per cycle; read data is valid in the same cycle.
// Assumes the decoder strobes only while busy_o is low and holds the
// accumulator value on acc_i for the cycle after the strobe.
module int_stack_seq
    import int_stack_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter logic [AW-DW-1:0] STACK_PAGE = 'h01,
    parameter logic [AW-1:0] VEC_NMI = 16'hFFFA,
    parameter logic [AW-1:0] VEC_RST = 16'hFFFC,
    parameter logic [AW-1:0] VEC_IRQ = 16'hFFFE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          nmi_i,
    input  logic          irq_i,
    input  logic          start_i,
    input  logic [2:0]    cmd_i,
    input  logic [DW-1:0] opnd_lo_i,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] rdata_i,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wdata_o,
    output logic          we_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [AW-1:0] pc_o,
    output logic [DW-1:0] sp_o,
    output logic [DW-1:0] status_o,
    output logic [DW-1:0] acc_o,
    output logic          acc_we_o,
    output logic          regs_clr_o
);
    localparam logic [DW-1:0] FORCE = DW'(ST_PUSH_FORCE);

    seq_kind_e     kind_q, go_kind;
    logic          busy_q, done_q, acc_we_q, go;
    logic [2:0]    step_q, last;
    logic [AW-1:0] pc_q, stk_addr, vec, vec_addr;
    logic [DW-1:0] opnd_q, acc_q, stat;
    logic          sp_push, sp_pull, st_seti, st_load, st_nz;
    logic          pc_lo, pc_hi, pc_call, pc_inc, acc_ld;

    int_stack_seq_arb u_arb (
        .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .irq_i(irq_i),
        .irq_mask_i(stat[ST_I]), .idle_i(!busy_q), .start_i(start_i),
        .cmd_i(cmd_i), .go_o(go), .kind_o(go_kind)
    );

    int_stack_seq_sp #(.AW(AW), .DW(DW), .STACK_PAGE(STACK_PAGE)) u_sp (
        .clk(clk), .rst_n(rst_n), .push_i(sp_push), .pull_i(sp_pull),
        .sp_o(sp_o), .addr_o(stk_addr)
    );

    int_stack_seq_status #(.DW(DW)) u_st (
        .clk(clk), .rst_n(rst_n), .set_idis_i(st_seti),
        .set_brk_i(go && (go_kind == K_BRK)), .load_i(st_load),
        .nz_i(st_nz), .val_i(rdata_i), .stat_o(stat)
    );

    // Vector base for the running kind, low byte first.
    always_comb begin
        case (kind_q)
            K_RST:   vec = VEC_RST;
            K_NMI:   vec = VEC_NMI;
            default: vec = VEC_IRQ;
        endcase
    end

    assign last     = last_step(kind_q);
    assign vec_addr = (step_q == last) ? vec + 1'b1 : vec;

    // Per-step bus access and register update requests.
    always_comb begin
        addr_o = pc_q; wdata_o = '0; we_o = 1'b0;
        sp_push = 1'b0; sp_pull = 1'b0;
        st_seti = 1'b0; st_load = 1'b0; st_nz = 1'b0;
        pc_lo = 1'b0; pc_hi = 1'b0; pc_call = 1'b0; pc_inc = 1'b0;
        acc_ld = 1'b0;
        if (busy_q) begin
            case (kind_q)
                K_RST: begin
                    addr_o = vec_addr;
                    pc_lo  = (step_q == 3'd0);
                    pc_hi  = (step_q == 3'd1);
                end
                K_NMI, K_IRQ, K_BRK: begin
                    if (step_q <= 3'd2) begin
                        addr_o = stk_addr; we_o = 1'b1; sp_push = 1'b1;
                        case (step_q)
                            3'd0:    wdata_o = pc_q[AW-1:DW];
                            3'd1:    wdata_o = pc_q[DW-1:0];
                            default: wdata_o = stat;
                        endcase
                    end else begin
                        addr_o  = vec_addr;
                        pc_lo   = (step_q == 3'd3);
                        pc_hi   = (step_q == 3'd4);
                        st_seti = (step_q == 3'd4);
                    end
                end
                K_CALL: begin
                    if (step_q == 3'd3) begin
                        pc_call = 1'b1;
                    end else begin
                        addr_o  = stk_addr;
                        we_o    = (step_q != 3'd0);
                        sp_push = (step_q != 3'd0);
                        wdata_o = (step_q == 3'd1) ? pc_q[AW-1:DW] : pc_q[DW-1:0];
                    end
                end
                K_RET: begin
                    if (step_q == 3'd3) begin
                        pc_inc = 1'b1;
                    end else begin
                        addr_o  = stk_addr;
                        sp_pull = (step_q != 3'd2);
                        pc_lo   = (step_q == 3'd1);
                        pc_hi   = (step_q == 3'd2);
                    end
                end
                K_RETI: begin
                    addr_o  = stk_addr;
                    sp_pull = (step_q != 3'd3);
                    st_load = (step_q == 3'd1);
                    pc_lo   = (step_q == 3'd2);
                    pc_hi   = (step_q == 3'd3);
                end
                K_PUSHA, K_PUSHP: begin
                    addr_o  = stk_addr; we_o = 1'b1; sp_push = 1'b1;
                    wdata_o = (kind_q == K_PUSHA) ? acc_i : (stat | FORCE);
                end
                K_PULLA, K_PULLP: begin
                    addr_o  = stk_addr;
                    sp_pull = (step_q == 3'd0);
                    acc_ld  = (step_q == 3'd1) && (kind_q == K_PULLA);
                    st_nz   = acc_ld;
                    st_load = (step_q == 3'd1) && (kind_q == K_PULLP);
                end
                default: ;
            endcase
        end
    end

    // Sequence control, program counter and accumulator output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b1; kind_q <= K_RST; step_q <= '0;
            pc_q <= '0; opnd_q <= '0; acc_q <= '0;
            done_q <= 1'b0; acc_we_q <= 1'b0;
        end else begin
            done_q   <= 1'b0;
            acc_we_q <= acc_ld;
            if (acc_ld) acc_q <= rdata_i;
            if (!busy_q) begin
                if (go) begin
                    busy_q <= 1'b1;
                    kind_q <= go_kind;
                    step_q <= '0;
                    opnd_q <= opnd_lo_i;
                    if (go_kind == K_BRK) pc_q <= pc_q + 1'b1;
                end
            end else begin
                if (pc_lo)   pc_q[DW-1:0]    <= rdata_i;
                if (pc_hi)   pc_q[AW-1:DW]   <= rdata_i;
                if (pc_call) pc_q            <= {rdata_i, opnd_q};
                if (pc_inc)  pc_q            <= pc_q + 1'b1;
                if (step_q == last) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    step_q <= step_q + 1'b1;
                end
            end
        end
    end

    assign busy_o     = busy_q;
    assign done_o     = done_q;
    assign pc_o       = pc_q;
    assign status_o   = stat;
    assign acc_o      = acc_q;
    assign acc_we_o   = acc_we_q;
    assign regs_clr_o = busy_q && (kind_q == K_RST);
endmodule

// Checker: temporal properties of the sequencer's ports.
module int_stack_seq_chk #(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter logic [AW-DW-1:0] STACK_PAGE = 'h01
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr_o,
    input logic          we_o,
    input logic          busy_o,
    input logic          done_o,
    input logic [DW-1:0] sp_o,
    input logic [DW-1:0] status_o,
    input logic [DW-1:0] acc_o,
    input logic          acc_we_o
);
    AST_WRITE_ON_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> addr_o[AW-1:DW] == STACK_PAGE); // R2
    AST_PUSH_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |=> sp_o == DW'($past(sp_o) - 1'b1)); // R2
    AST_SP_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(busy_o) |-> $stable(sp_o)); // R2
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R12
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && $past(busy_o)); // R12
    AST_PULL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_we_o |-> (status_o[7] == acc_o[DW-1]) && (status_o[1] == (acc_o == '0))); // R11
endmodule

bind int_stack_seq int_stack_seq_chk #(.AW(AW), .DW(DW), .STACK_PAGE(STACK_PAGE)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr_o(addr_o), .we_o(we_o), .busy_o(busy_o),
    .done_o(done_o), .sp_o(sp_o), .status_o(status_o), .acc_o(acc_o),
    .acc_we_o(acc_we_o)
);

// File: tb/int_stack_seq_tb.sv
`timescale 1ns/1ps
module int_stack_seq_tb;
    localparam logic [2:0] C_BRK = 3'd0, C_CALL = 3'd1, C_RET = 3'd2, C_RETI = 3'd3;
    localparam logic [2:0] C_PHA = 3'd4, C_PHP = 3'd5, C_PLA = 3'd6, C_PLP = 3'd7;

    logic clk = 1'b0, rst_n = 1'b0, nmi = 1'b0, irq = 1'b0, start = 1'b0;
    logic [2:0] cmd = '0;
    logic [7:0] opnd = '0, acc_in = '0, rdata, wdata, sp, status, acc_out;
    logic [15:0] addr, pc;
    logic we, busy, done, acc_we, regs_clr;

    logic [7:0] mem [0:1023];
    logic [7:0] vmem [0:7];
    logic [15:0] log_a [0:15];
    logic [7:0]  log_d [0:15];
    logic        log_w [0:15];
    int log_n = 0, tests = 0, fails = 0;
    logic acc_we_seen = 1'b0, clr_seen = 1'b0;

    always #10 clk = ~clk;

    int_stack_seq u_dut (
        .clk(clk), .rst_n(rst_n), .nmi_i(nmi), .irq_i(irq), .start_i(start),
        .cmd_i(cmd), .opnd_lo_i(opnd), .acc_i(acc_in), .rdata_i(rdata),
        .addr_o(addr), .wdata_o(wdata), .we_o(we), .busy_o(busy), .done_o(done),
        .pc_o(pc), .sp_o(sp), .status_o(status), .acc_o(acc_out),
        .acc_we_o(acc_we), .regs_clr_o(regs_clr)
    );

    assign rdata = (addr[15:3] == 13'h1FFF) ? vmem[addr[2:0]] : mem[addr[9:0]];

    always @(posedge clk) if (we) mem[addr[9:0]] <= wdata;

    // Bus cycle log, taken mid-cycle.
    always @(negedge clk) begin
        if (busy && log_n < 16) begin
            log_a[log_n] = addr; log_d[log_n] = wdata; log_w[log_n] = we;
            log_n = log_n + 1;
        end
        if (acc_we) acc_we_seen = 1'b1;
        if (regs_clr) clr_seen = 1'b1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_log(input string tag, input int i, input logic w,
                           input logic [15:0] a, input logic [7:0] d);
        chk(tag, {7'd0, log_w[i], log_a[i], log_w[i] ? log_d[i] : 8'h00},
                 {7'd0, w, a, w ? d : 8'h00});
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 40) begin @(negedge clk); n++; end
        chk({tag, " done"}, {31'd0, done}, 32'd1);
        @(negedge clk);
        chk({tag, " done one cycle"}, {31'd0, done}, 32'd0);
    endtask

    task automatic strobe(input logic [2:0] c, input logic [7:0] o, input logic [7:0] a);
        @(negedge clk);
        log_n = 0; acc_we_seen = 1'b0;
        start = 1'b1; cmd = c; opnd = o; acc_in = a;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_cmd(input string tag, input logic [2:0] c,
                           input logic [7:0] o, input logic [7:0] a);
        strobe(c, o, a);
        wait_done(tag);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 sp in reset", {24'd0, sp}, 32'hFF);
        chk("R1 status in reset", {24'd0, status}, 32'h00);
        chk("R1 regs_clr in reset", {31'd0, regs_clr}, 32'd1);
        rst_n = 1'b1;
        wait_done("R1");
        chk("R1 pc from vector", {16'd0, pc}, 32'h0234);
        chk("R1 regs_clr after", {31'd0, regs_clr}, 32'd0);
    endtask

    task automatic t_acc_push_pull;
        run_cmd("R6 push A", C_PHA, 8'h00, 8'h80);
        chk_log("R2 R6 push A write", 0, 1'b1, 16'h01FF, 8'h80);
        chk("R2 push decrement", {24'd0, sp}, 32'hFE);
        run_cmd("R11 pull A", C_PLA, 8'h00, 8'h00);
        chk_log("R2 pull dummy", 0, 1'b0, 16'h01FE, 8'h00);
        chk_log("R2 pull read after inc", 1, 1'b0, 16'h01FF, 8'h00);
        chk("R11 acc N value", {23'd0, acc_we_seen, acc_out}, {23'd0, 1'b1, 8'h80});
        chk("R11 N set", {24'd0, status}, 32'h80);
        run_cmd("R6 push zero", C_PHA, 8'h00, 8'h00);
        run_cmd("R11 pull zero", C_PLA, 8'h00, 8'h00);
        chk("R11 Z set N clear", {24'd0, status, acc_out}, 32'h0200);
        run_cmd("R6 push status", C_PHP, 8'h00, 8'h00);
        chk_log("R6 status forced bits", 0, 1'b1, 16'h01FF, 8'h32);
        chk("R6 status register unchanged", {24'd0, status}, 32'h02);
        run_cmd("R11 pull back", C_PLA, 8'h00, 8'h00);
        chk("R11 pulled 0x32", {16'd0, acc_out, status}, 32'h3200);
    endtask

    task automatic t_status_pull;
        mem[10'h100] = 8'hFF;
        run_cmd("R7 pull status", C_PLP, 8'h00, 8'h00);
        chk_log("R2 pointer wrap read", 1, 1'b0, 16'h0100, 8'h00);
        chk("R7 masked load", {16'd0, sp, status}, 32'h00CF);
        run_cmd("R6 push at 0x00", C_PHP, 8'h00, 8'h00);
        chk_log("R2 R6 push at page start", 0, 1'b1, 16'h0100, 8'hFF);
        chk("R2 wrap back", {24'd0, sp}, 32'hFF);
        @(negedge clk);
        log_n = 0; irq = 1'b1;
        repeat (6) @(negedge clk);
        irq = 1'b0;
        chk("R4 masked irq ignored", {log_n[15:0], pc}, {16'd0, 16'h0234});
        mem[10'h100] = 8'h00;
        run_cmd("R7 clear mask", C_PLP, 8'h00, 8'h00);
        chk("R7 bits 4,5 kept clear", {24'd0, status}, 32'h00);
        run_cmd("R2 realign", C_PHA, 8'h00, 8'h00);
        chk("R2 realigned sp", {24'd0, sp}, 32'hFF);
    endtask

    task automatic t_irq_nmi;
        @(negedge clk); log_n = 0; irq = 1'b1;
        @(negedge clk);
        wait_done("R3 irq");
        irq = 1'b0;
        chk_log("R3 irq pch", 0, 1'b1, 16'h01FF, 8'h02);
        chk_log("R3 irq pcl", 1, 1'b1, 16'h01FE, 8'h34);
        chk_log("R3 irq status", 2, 1'b1, 16'h01FD, 8'h00);
        chk_log("R3 irq vec lo", 3, 1'b0, 16'hFFFE, 8'h00);
        chk_log("R3 irq vec hi", 4, 1'b0, 16'hFFFF, 8'h00);
        chk("R3 irq result", {pc, sp, status}, {16'h0300, 8'hFC, 8'h04});
        @(negedge clk); log_n = 0; nmi = 1'b1;
        @(negedge clk); nmi = 1'b0;
        wait_done("R4 nmi masked");
        chk_log("R3 nmi status pushed", 2, 1'b1, 16'h01FA, 8'h04);
        chk_log("R3 nmi vec lo", 3, 1'b0, 16'hFFFA, 8'h00);
        chk("R4 nmi despite mask", {pc, sp, status}, {16'h0280, 8'hF9, 8'h04});
        run_cmd("R10 rti", C_RETI, 8'h00, 8'h00);
        chk("R10 rti cycles", log_n, 32'd4);
        chk("R10 rti one", {pc, sp, status}, {16'h0300, 8'hFC, 8'h04});
        run_cmd("R10 rti two", C_RETI, 8'h00, 8'h00);
        chk("R10 rti no increment", {pc, sp, status}, {16'h0234, 8'hFF, 8'h00});
        @(negedge clk); log_n = 0; irq = 1'b1; nmi = 1'b1;
        @(negedge clk); nmi = 1'b0;
        wait_done("R4 both");
        irq = 1'b0;
        chk_log("R4 priority vector", 3, 1'b0, 16'hFFFA, 8'h00);
        chk("R4 nmi wins", {pc, status}, {8'd0, 16'h0280, 8'h04});
        run_cmd("R10 back", C_RETI, 8'h00, 8'h00);
        chk("R10 back state", {pc, sp, status}, {16'h0234, 8'hFF, 8'h00});
    endtask

    task automatic t_call_ret;
        mem[10'h234] = 8'h03;
        strobe(C_CALL, 8'h50, 8'h00);
        start = 1'b1; cmd = C_PHA; acc_in = 8'hEE;
        @(negedge clk);
        start = 1'b0;
        wait_done("R8 call");
        chk("R12 stray strobe ignored", log_n, 32'd4);
        chk_log("R8 dummy stack read", 0, 1'b0, 16'h01FF, 8'h00);
        chk_log("R8 push high", 1, 1'b1, 16'h01FF, 8'h02);
        chk_log("R8 push low", 2, 1'b1, 16'h01FE, 8'h34);
        chk_log("R8 target high read", 3, 1'b0, 16'h0234, 8'h00);
        repeat (3) @(negedge clk);
        chk("R8 R12 call result", {pc, sp, busy}, {16'h0350, 8'hFD, 1'b0});
        run_cmd("R9 return", C_RET, 8'h00, 8'h00);
        chk("R9 four cycles", log_n, 32'd4);
        chk_log("R9 low pull", 1, 1'b0, 16'h01FE, 8'h00);
        chk_log("R9 high pull", 2, 1'b0, 16'h01FF, 8'h00);
        chk("R9 plus one", {pc, sp}, {8'd0, 16'h0235, 8'hFF});
    endtask

    task automatic t_nmi_latch_brk;
        strobe(C_PHA, 8'h00, 8'h11);
        nmi = 1'b1;
        @(negedge clk);
        nmi = 1'b0;
        chk("R12 push done", {31'd0, done}, 32'd1);
        @(negedge clk);
        wait_done("R4 latched nmi");
        chk("R4 latched log", log_n, 32'd6);
        chk_log("R4 latched pch", 1, 1'b1, 16'h01FE, 8'h02);
        chk_log("R4 latched status", 3, 1'b1, 16'h01FC, 8'h00);
        chk("R4 latched result", {pc, sp, status}, {16'h0280, 8'hFB, 8'h04});
        run_cmd("R10 leave", C_RETI, 8'h00, 8'h00);
        run_cmd("R11 drop", C_PLA, 8'h00, 8'h00);
        chk("R11 dropped 0x11", {pc, sp, acc_out}, {16'h0235, 8'hFF, 8'h11});
        run_cmd("R5 break", C_BRK, 8'h00, 8'h00);
        chk_log("R5 pch", 0, 1'b1, 16'h01FF, 8'h02);
        chk_log("R5 pcl plus one", 1, 1'b1, 16'h01FE, 8'h36);
        chk_log("R5 marks pushed", 2, 1'b1, 16'h01FD, 8'h30);
        chk_log("R5 vector", 3, 1'b0, 16'hFFFE, 8'h00);
        chk("R5 result", {pc, sp, status}, {16'h0300, 8'hFC, 8'h34});
        run_cmd("R7 rti", C_RETI, 8'h00, 8'h00);
        chk("R7 R10 marks kept", {pc, sp, status}, {16'h0236, 8'hFF, 8'h30});
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        for (int i = 0; i < 8; i++) vmem[i] = 8'h00;
        vmem[2] = 8'h80; vmem[3] = 8'h02;
        vmem[4] = 8'h34; vmem[5] = 8'h02;
        vmem[6] = 8'h00; vmem[7] = 8'h03;
        t_reset();
        chk("R1 clear seen", {31'd0, clr_seen}, 32'd1);
        t_acc_push_pull();
        t_status_pull();
        t_irq_nmi();
        t_call_ret();
        t_nmi_latch_brk();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule